// File: doc/BRIEF.md
# Dual-Mode Interrupt Down-Counter

This block raises a timed interrupt for a CPU by counting events down from a programmed value. It can be clocked in two ways. In scanline mode, each qualified rising edge of a monitored graphics address line is one event. In cycle mode, an internal prescaler turns every fourth CPU clock into an event. Four address-decoded write strobes and a data byte program the block. One stores the reload value. One selects the mode and arms a counter reset. One acknowledges the interrupt and disables it. One enables it.

A counter reset loads the reload value plus one, so the counter is nine bits wide. When the counter reaches zero by decrementing while interrupts are enabled, the block starts a short delay. After that delay the active-low request goes low, and it stays low until software acknowledges it. The counter keeps running while interrupts are disabled.

Top module: `dual_irq_counter`

## Requirements
- R1: While reset is held and after it is released, `irq_n` is 1. Interrupts are disabled, the mode is scanline, no counter reset is pending, and the counter and reload value are 0.
- R2: A `wr_reload` strobe stores `wr_data` as the reload value. A `wr_ctrl` strobe takes `wr_data[0]` as the mode (0 = scanline, 1 = CPU cycle) and arms a pending counter reset.
- R3: On a counter clock with a reset pending, the counter loads reload+1 and the pending flag clears. A reload of 255 gives 256 without wrapping, so 256 further clocks pass before the counter next reaches zero.
- R4: On a counter clock with no reset pending, a counter at 0 takes the reload value. Any other value decrements, and reaching 0 while interrupts are enabled raises an interrupt. Without a counter clock the counter holds its value.
- R5: While interrupts are disabled the counter still counts and reloads, but no interrupt is raised.
- R6: In cycle mode a counter clock happens once every 4 CPU cycles. The cycle in which `wr_ctrl` is high restarts the prescaler, and the first clock after it falls in the 4th cycle after that write cycle.
- R7: In scanline mode a counter clock happens in a cycle where `line_in` is 1 and was 0 in each of the preceding 3 or more cycles. A line that stays high gives no further clock. Line edges are ignored in cycle mode, and prescaler clocks are ignored in scanline mode.
- R8: `irq_n` goes low `IRQ_DELAY` (default 2) clock edges after the edge that brought the counter to zero. It then stays low until acknowledged.
- R9: A `wr_ack` strobe releases `irq_n` at the next edge, cancels an interrupt still in its delay, and disables interrupts. A `wr_enable` strobe enables them. If both strobes arrive in the same cycle, interrupts end up disabled.
- R10: When a `wr_ctrl` or `wr_reload` write falls in the same cycle as a counter clock, the clock is processed with the old mode, reload value and pending flag. The write takes effect afterwards, so after a same-cycle `wr_ctrl` a reset is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_reload | input | 1 | Write strobe: store reload value |
| wr_ctrl | input | 1 | Write strobe: mode select and counter reset |
| wr_ack | input | 1 | Write strobe: acknowledge and disable interrupts |
| wr_enable | input | 1 | Write strobe: enable interrupts |
| wr_data | input | 8 | CPU write data |
| line_in | input | 1 | Monitored graphics address line |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A counter clock and a CPU write can land in the same cycle. The case covered is a mode/reset write or a reload write arriving in the cycle where the address line rises after a qualifying low run. The bench provokes this by placing the strobe in exactly that rising cycle, and also drives an acknowledge and an enable together. A behavioural model processes each clock with the old register values and then applies the write. The model's request level is compared with `irq_n` on every cycle, so a wrong priority shows up as an interrupt that comes one period early or late.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic {
    SRC_LINE  = 1'b0,
    SRC_CYCLE = 1'b1
  } tick_src_e;
endpackage

// File: rtl/dic_line_filter.sv
module dic_line_filter #(
  parameter int LOW_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic tick
);
  localparam int RUN_W = $clog2(LOW_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOW_MIN);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (line_in)             run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign tick = line_in && (run_q == RUN_MAX);

  // R7: a held-high line gives a single event
  assert_single_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dic_prescaler.sv
module dic_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = $clog2(DIV);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    if (restart)          pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = !restart && (pre_q == LAST);

  // R6: no event right after a restart
  assert_restart_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dic_core.sv
module dic_core
  import dic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic              wr_ack,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_clk,
  output tick_src_e         src,
  output logic              fire
);
  localparam int CNT_W = DATA_W + 1;

  logic [DATA_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              en_q, en_d;
  tick_src_e         src_q, src_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clk) begin
      if (pend_q)          cnt_d = {1'b0, reload_q} + CNT_W'(1);
      else if (cnt_q == '0) cnt_d = {1'b0, reload_q};
      else                 cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    reload_d = wr_reload ? wr_data : reload_q;
    src_d    = wr_ctrl ? tick_src_e'(wr_data[0]) : src_q;
    pend_d   = wr_ctrl ? 1'b1 : (cnt_clk ? 1'b0 : pend_q);
    en_d     = wr_ack ? 1'b0 : (wr_enable ? 1'b1 : en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      en_q     <= 1'b0;
      src_q    <= SRC_LINE;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      en_q     <= en_d;
      src_q    <= src_d;
    end
  end

  assign fire = cnt_clk && !pend_q && (cnt_q == CNT_W'(1)) && en_q;
  assign src  = src_q;

  assert_pend_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> pend_q);
  assert_reset_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clk && pend_q) |=> (cnt_q == ({1'b0, $past(reload_q)} + CNT_W'(1))));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clk && !pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clk |=> $stable(cnt_q));
  assert_ack_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !en_q);
endmodule

// File: rtl/dic_delay.sv
module dic_delay #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq_n
);
  logic req_q, req_d;

  generate
    if (DELAY == 0) begin : g_direct
      always_comb begin
        if (ack)       req_d = 1'b0;
        else if (fire) req_d = 1'b1;
        else           req_d = req_q;
      end
    end else begin : g_timed
      localparam int DLY_W = $clog2(DELAY + 1);
      logic [DLY_W-1:0] dly_q, dly_d;

      always_comb begin
        if (ack)               dly_d = '0;
        else if (fire)         dly_d = DLY_W'(DELAY);
        else if (dly_q != '0)  dly_d = dly_q - 1'b1;
        else                   dly_d = dly_q;
        if (ack)                      req_d = 1'b0;
        else if (dly_q == DLY_W'(1))  req_d = 1'b1;
        else                          req_d = req_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq_n = !req_q;

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !ack) |=> !irq_n);
  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> irq_n);
endmodule

// File: rtl/dual_irq_counter.sv
module dual_irq_counter
  import dic_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PRE_DIV   = 4,
  parameter int LOW_MIN   = 3,
  parameter int IRQ_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic              wr_ack,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_in,
  output logic              irq_n
);
  logic      rst_s1_q, rst_s2_q;
  logic      rst_int_n;
  logic      line_tick, cyc_tick, cnt_clk, fire;
  tick_src_e src;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  dic_line_filter #(.LOW_MIN(LOW_MIN)) u_line (
    .clk(clk), .rst_n(rst_int_n), .line_in(line_in), .tick(line_tick)
  );

  dic_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .restart(wr_ctrl), .tick(cyc_tick)
  );

  assign cnt_clk = (src == SRC_CYCLE) ? cyc_tick : line_tick;

  dic_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_int_n),
    .wr_reload(wr_reload), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack),
    .wr_enable(wr_enable), .wr_data(wr_data),
    .cnt_clk(cnt_clk), .src(src), .fire(fire)
  );

  dic_delay #(.DELAY(IRQ_DELAY)) u_dly (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .ack(wr_ack), .irq_n(irq_n)
  );
endmodule

// File: tb/test_dual_irq_counter.sv
module test_dual_irq_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_MIN    = 3;
  localparam int IRQ_DELAY  = 2;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_reload, wr_ctrl, wr_ack, wr_enable;
  logic [7:0] wr_data;
  logic       line_in;
  logic       irq_n;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_reload, m_cnt, m_pre, m_low;
  bit m_pend, m_en, m_mode, m_req;
  int m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_counter #(.LOW_MIN(LOW_MIN), .IRQ_DELAY(IRQ_DELAY)) i_dual_irq_counter (
    .clk(clk), .rst_n(rst_n), .wr_reload(wr_reload), .wr_ctrl(wr_ctrl),
    .wr_ack(wr_ack), .wr_enable(wr_enable), .wr_data(wr_data),
    .line_in(line_in), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reload = 0; m_cnt = 0; m_pre = 0; m_low = 0;
      m_pend = 0; m_en = 0; m_mode = 0; m_req = 0;
      m_q.delete();
    end else begin
      bit tick, fire;
      tick = m_mode ? (!wr_ctrl && m_pre == 3) : (line_in && m_low >= LOW_MIN);
      fire = 0;
      if (tick) begin
        if (m_pend) m_cnt = m_reload + 1;
        else if (m_cnt == 0) m_cnt = m_reload;
        else begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0 && m_en) fire = 1;
        end
      end
      if (wr_ack) begin
        m_req = 0;
        m_q.delete();
      end else begin
        foreach (m_q[i]) begin
          m_q[i] = m_q[i] - 1;
          if (m_q[i] == 0) m_req = 1;
        end
        while (m_q.size() > 0 && m_q[0] <= 0) void'(m_q.pop_front());
        if (fire) begin
          if (IRQ_DELAY == 0) m_req = 1;
          else m_q.push_back(IRQ_DELAY);
        end
      end
      m_pend = wr_ctrl ? 1'b1 : (tick ? 1'b0 : m_pend);
      if (wr_ack) m_en = 0; else if (wr_enable) m_en = 1;
      if (wr_reload) m_reload = wr_data;
      if (wr_ctrl) m_mode = wr_data[0];
      m_pre = wr_ctrl ? 0 : (m_pre + 1) % 4;
      m_low = line_in ? 0 : ((m_low < LOW_MIN) ? m_low + 1 : LOW_MIN);
    end
  end

  task automatic check(input bit cond, input string tag, input logic act, input logic exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s irq_n actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) check(irq_n === !m_req, cur_req, irq_n, !m_req);
  end

  task automatic step(input bit r, input bit c, input bit a, input bit e,
                      input logic [7:0] d, input bit l);
    wr_reload = r; wr_ctrl = c; wr_ack = a; wr_enable = e;
    wr_data = d; line_in = l;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, 1);
  endtask

  task automatic scan(input int lo, input int hi);
    for (int i = 0; i < lo; i++) step(0, 0, 0, 0, 8'h00, 0);
    for (int i = 0; i < hi; i++) step(0, 0, 0, 0, 8'h00, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finish_run();
  end

  initial begin
    rst_n = 0; wr_reload = 0; wr_ctrl = 0; wr_ack = 0; wr_enable = 0;
    wr_data = 0; line_in = 1;
    repeat (4) @(negedge clk);
    check(irq_n === 1'b1, "R1", irq_n, 1'b1);
    rst_n = 1;
    idle(4);
    check(irq_n === 1'b1, "R1", irq_n, 1'b1);
    scan(4, 4);

    cur_req = "R2";
    step(1, 0, 0, 0, 8'd3, 1);
    step(0, 1, 0, 0, 8'd0, 1);
    step(0, 0, 0, 1, 8'd0, 1);

    cur_req = "R8";
    for (int i = 0; i < 12; i++) scan(4, 4);

    cur_req = "R9";
    step(0, 0, 1, 0, 8'd0, 1);
    check(irq_n === 1'b1, "R9", irq_n, 1'b1);

    cur_req = "R5";
    for (int i = 0; i < 10; i++) scan(4, 4);

    cur_req = "R4";
    step(0, 0, 0, 1, 8'd0, 1);
    for (int i = 0; i < 10; i++) scan(5, 2);
    step(0, 0, 1, 0, 8'd0, 1);
    step(0, 0, 0, 1, 8'd0, 1);

    cur_req = "R7";
    for (int i = 0; i < 8; i++) scan(2, 3);
    for (int i = 0; i < 4; i++) scan(1, 1);
    for (int i = 0; i < 8; i++) scan(3, 1);
    step(0, 0, 1, 0, 8'd0, 1);
    step(0, 0, 0, 1, 8'd0, 1);

    cur_req = "R10";
    step(1, 0, 0, 0, 8'd5, 1);
    scan(4, 0);
    step(0, 1, 0, 0, 8'd0, 1);
    idle(3);
    for (int i = 0; i < 3; i++) scan(4, 2);
    scan(4, 0);
    step(1, 0, 0, 0, 8'd2, 1);
    idle(3);
    for (int i = 0; i < 10; i++) scan(4, 2);
    step(0, 0, 1, 1, 8'd0, 1);
    check(irq_n === 1'b1, "R9", irq_n, 1'b1);
    for (int i = 0; i < 10; i++) scan(4, 2);

    cur_req = "R6";
    step(0, 0, 0, 1, 8'd0, 1);
    step(0, 1, 0, 0, 8'd1, 1);
    step(1, 0, 0, 0, 8'd2, 1);
    for (int i = 0; i < 10; i++) scan(4, 4);
    for (int i = 0; i < 6; i++) begin
      idle(17 + i);
      step(0, 0, 1, 0, 8'd0, 1);
      step(0, 0, 0, 1, 8'd0, 1);
    end
    idle(2);
    step(0, 1, 0, 0, 8'd1, 1);
    idle(3);
    step(0, 1, 0, 0, 8'd1, 1);
    idle(1);
    step(0, 1, 0, 0, 8'd1, 1);
    idle(40);

    cur_req = "R3";
    step(1, 0, 0, 0, 8'd255, 1);
    step(0, 1, 0, 0, 8'd1, 1);
    step(0, 0, 1, 0, 8'd0, 1);
    step(0, 0, 0, 1, 8'd0, 1);
    idle(1100);
    step(0, 0, 1, 0, 8'd0, 1);

    cur_req = "R7";
    step(1, 0, 0, 0, 8'd1, 1);
    step(0, 1, 0, 0, 8'd0, 1);
    step(0, 0, 0, 1, 8'd0, 1);
    idle(30);
    for (int i = 0; i < 8; i++) scan(4, 3);
    idle(4);
    finish_run();
  end
endmodule